// File: doc/BRIEF.md
# Banked GPIO Register File

This block holds the configuration of up to 56 general-purpose pins behind a byte-wide synchronous register port. Every pin owns one bit in each of four writable register kinds (function select, direction, output level, pull-down enable) and one bit in a read-only input kind. Each kind is a run of seven consecutive byte registers, eight pins to a byte, and the kinds are spaced 0x10 apart in the address space. Pins are numbered from 1: pin N lives at bit (N-1) mod 8 of register base + (N-1)/8.

A short contiguous range of high pins (51 to 54 by default) also owns a two-bit pull field in a shared byte, which can request either a pull-up or a pull-down and replaces the single pull-down bit for those pins. Two further byte registers, an input-voltage select and an alternate-function byte, are stored and driven straight out to neighbouring logic. Pad inputs go through a two-flop synchronizer before they can be read. The host updates single bits by read-modify-write of whole bytes.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every register reads 0x00 and every pad output, output enable, pull-up, pull-down and function-select line is 0.
- R2: The writable kinds sit at base offsets 0x00 (function select), 0x10 (direction), 0x20 (output level) and 0x30 (pull-down), each with registers +0 to +6; a byte written there reads back unchanged, and pin N maps to bit (N-1) mod 8 of register base + (N-1)/8.
- R3: pad_oe of pin N equals its direction bit (1 = output, 0 = input) and pad_out of pin N equals its output-level bit whatever the direction.
- R4: For a pin outside the two-bit pull range that is an input, pad_pd equals its pull-down bit and pad_pu is 0.
- R5: The byte at 0x48 holds a two-bit field at bit 2*(N-51) for each pin N in 51..54, coded 01 = pull-down, 10 = pull-up, 00 and 11 = no pull; for these pins the pull-down bit of the 0x30 kind has no effect.
- R6: A pin whose direction bit is 1 has both pad_pu and pad_pd at 0.
- R7: A change on pad_in is returned by a read of the input kind (base 0x40, +0 to +6, same pin-to-bit mapping as R2) only when the read is sampled on the third rising edge after the change; reads sampled on the first two still return the old value.
- R8: A read of an unmapped offset returns 0x00; a write to an unmapped offset or to the input kind changes no register and no pad line.
- R9: The byte at 0x47 (input-voltage select) and the byte at 0x50 (alternate function) read back as written and appear on vsel_code and alt_func.
- R10: pin_func_sel of pin N equals its function-select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one byte |
| reg_rd | input | 1 | Read strobe; data returned on reg_rdata after the next edge |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, held until the next read |
| pad_in | input | 56 | Asynchronous pad inputs, bit N-1 is pin N |
| pad_out | output | 56 | Output level to the pads |
| pad_oe | output | 56 | Output enable to the pads |
| pad_pu | output | 56 | Pull-up enable to the pads |
| pad_pd | output | 56 | Pull-down enable to the pads |
| pin_func_sel | output | 56 | Per-pin function-select bits |
| vsel_code | output | 8 | Input-voltage select byte |
| alt_func | output | 8 | Alternate-function byte |

## Verification
A write lands on the rising edge where reg_wr is high, and every pad line follows combinationally from the registers, so the bench drives each access on a falling edge and checks the pads on the next falling edge. Read data is registered on the edge that sees reg_rd, so it is sampled one falling edge after the strobe. Pad inputs need two synchronizer edges plus the read register, so the bench holds a read of the input byte across the change and expects the old value after the first and second edges and the new one after the third.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned KIND_STRIDE     = 'h10;
   localparam int unsigned NUM_STORE_KINDS = 4;
   localparam int unsigned IN_BASE         = 'h40;
   localparam int unsigned VSEL_OFFS       = 'h47;
   localparam int unsigned PULL2_OFFS      = 'h48;
   localparam int unsigned ALT_OFFS        = 'h50;

   typedef enum int unsigned {
      K_FSEL = 0,
      K_DIR  = 1,
      K_OUT  = 2,
      K_PDN  = 3
   } store_kind_e;

   typedef struct packed {
      logic up;
      logic down;
   } pull_req_t;

   function automatic pull_req_t decode_pull2(input logic [1:0] field);
      pull_req_t r;
      r.up   = (field == 2'b10);
      r.down = (field == 2'b01);
      return r;
   endfunction

endpackage

// File: rtl/gpio_byte_bank.sv
module gpio_byte_bank #(
   parameter int unsigned BANKS  = 7,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned BASE   = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [7:0]           wdata,
   output logic                 hit,
   output logic [7:0]           rd_byte,
   output logic [8*BANKS-1:0]   bits
);

   logic [BANKS-1:0]       sel;
   logic [BANKS-1:0][7:0]  regs;

   for (genvar b = 0; b < BANKS; b++) begin : g_byte
      assign sel[b] = (addr == ADDR_W'(BASE + b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[b] <= '0;
         end else if (wr_en && sel[b]) begin
            regs[b] <= wdata;
         end
      end

      assign bits[8*b +: 8] = regs[b];
   end

   assign hit = |sel;

   always_comb begin
      rd_byte = '0;
      for (int b = 0; b < BANKS; b++) begin
         if (sel[b]) begin
            rd_byte = rd_byte | regs[b];
         end
      end
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 56,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must lie in 2..4");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

   // Edges seen since reset, saturating; gates the latency check below.
   logic [2:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm <= '0;
      end else if (warm != 3'(STAGES)) begin
         warm <= warm + 3'd1;
      end
   end

   // R7: synchronized value equals the pad value STAGES edges earlier
   p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 3'(STAGES)) |-> (q == $past(d, STAGES)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 56,
   parameter int unsigned P2_FIRST = 51,
   parameter int unsigned P2_LAST  = 54
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] dir_bits,
   input  logic [NUM_PINS-1:0] out_bits,
   input  logic [NUM_PINS-1:0] pdn_bits,
   input  logic [7:0]          pull2_reg,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_pu,
   output logic [NUM_PINS-1:0] pad_pd
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam int unsigned PIN = i + 1;
      pull_req_t req;

      if (PIN >= P2_FIRST && PIN <= P2_LAST) begin : g_dual
         localparam int unsigned FLD = 2 * (PIN - P2_FIRST);
         assign req = decode_pull2(pull2_reg[FLD +: 2]);

         // R5: a pull-up field on an input pin reaches the pad
         p_field_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!dir_bits[i] && pull2_reg[FLD +: 2] == 2'b10) |-> (pad_pu[i] && !pad_pd[i]));
         // R5: the legacy pull-down bit alone never pulls this pin
         p_legacy_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pull2_reg[FLD +: 2] != 2'b01) |-> !pad_pd[i]);
      end else begin : g_legacy
         assign req = '{up: 1'b0, down: pdn_bits[i]};
      end

      assign pad_oe[i]  = dir_bits[i];
      assign pad_out[i] = out_bits[i];
      assign pad_pu[i]  = req.up   & ~dir_bits[i];
      assign pad_pd[i]  = req.down & ~dir_bits[i];

      // R6: a driven pin carries no pull
      p_oe_no_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
         pad_oe[i] |-> !(pad_pu[i] || pad_pd[i]));
   end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 56,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned P2_FIRST    = 51,
   parameter int unsigned P2_LAST     = 54,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [7:0]          reg_wdata,
   output logic [7:0]          reg_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu,
   output logic [NUM_PINS-1:0] pad_pd,
   output logic [NUM_PINS-1:0] pin_func_sel,
   output logic [7:0]          vsel_code,
   output logic [7:0]          alt_func
);

   localparam int unsigned BANKS = (NUM_PINS + 7) / 8;
   localparam int unsigned BITS  = BANKS * 8;

   if (BANKS < 2 || BANKS > 7) begin : g_bad_banks
      $error("gpio_bank_regs: NUM_PINS must need 2..7 byte registers per kind");
   end
   if (P2_FIRST < 1 || P2_LAST < P2_FIRST || P2_LAST > NUM_PINS
       || (P2_LAST - P2_FIRST) > 3) begin : g_bad_pull2
      $error("gpio_bank_regs: two-bit pull range must hold 1..4 existing pins");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpio_bank_regs: ADDR_W too small for the register map");
   end

   // ---------------- per-pin byte banks ----------------
   logic [NUM_STORE_KINDS-1:0][BITS-1:0] store_bits;
   logic [NUM_STORE_KINDS-1:0]           store_hit;
   logic [NUM_STORE_KINDS-1:0][7:0]      store_rd;

   for (genvar k = 0; k < NUM_STORE_KINDS; k++) begin : g_kind
      gpio_byte_bank #(
         .BANKS  (BANKS),
         .ADDR_W (ADDR_W),
         .BASE   (k * KIND_STRIDE)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_wr),
         .addr    (reg_addr),
         .wdata   (reg_wdata),
         .hit     (store_hit[k]),
         .rd_byte (store_rd[k]),
         .bits    (store_bits[k])
      );
   end

   // ---------------- single-byte registers ----------------
   logic       vsel_hit, pull2_hit, alt_hit;
   logic [7:0] vsel_q, pull2_q, alt_q;

   assign vsel_hit  = (reg_addr == ADDR_W'(VSEL_OFFS));
   assign pull2_hit = (reg_addr == ADDR_W'(PULL2_OFFS));
   assign alt_hit   = (reg_addr == ADDR_W'(ALT_OFFS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsel_q  <= '0;
         pull2_q <= '0;
         alt_q   <= '0;
      end else if (reg_wr) begin
         if (vsel_hit)  vsel_q  <= reg_wdata;
         if (pull2_hit) pull2_q <= reg_wdata;
         if (alt_hit)   alt_q   <= reg_wdata;
      end
   end

   assign vsel_code = vsel_q;
   assign alt_func  = alt_q;

   // ---------------- input sampling ----------------
   logic [NUM_PINS-1:0] pad_sync;
   logic [BITS-1:0]     in_word;
   logic [BANKS-1:0]    in_sel;

   gpio_in_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   assign in_word = BITS'(pad_sync);

   for (genvar b = 0; b < BANKS; b++) begin : g_in_sel
      assign in_sel[b] = (reg_addr == ADDR_W'(IN_BASE + b));
   end

   // ---------------- read path ----------------
   logic [7:0] rd_next;
   logic       addr_mapped;
   logic       addr_storing;

   assign addr_storing = (|store_hit) | vsel_hit | pull2_hit | alt_hit;
   assign addr_mapped  = addr_storing | (|in_sel);

   always_comb begin
      rd_next = '0;
      for (int k = 0; k < NUM_STORE_KINDS; k++) begin
         rd_next = rd_next | store_rd[k];
      end
      for (int b = 0; b < BANKS; b++) begin
         if (in_sel[b]) begin
            rd_next = rd_next | in_word[8*b +: 8];
         end
      end
      if (vsel_hit)  rd_next = rd_next | vsel_q;
      if (pull2_hit) rd_next = rd_next | pull2_q;
      if (alt_hit)   rd_next = rd_next | alt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         reg_rdata <= rd_next;
      end
   end

   // ---------------- pad control ----------------
   assign pin_func_sel = store_bits[K_FSEL][NUM_PINS-1:0];

   gpio_pad_ctrl #(
      .NUM_PINS (NUM_PINS),
      .P2_FIRST (P2_FIRST),
      .P2_LAST  (P2_LAST)
   ) u_pad (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir_bits  (store_bits[K_DIR][NUM_PINS-1:0]),
      .out_bits  (store_bits[K_OUT][NUM_PINS-1:0]),
      .pdn_bits  (store_bits[K_PDN][NUM_PINS-1:0]),
      .pull2_reg (pull2_q),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out),
      .pad_pu    (pad_pu),
      .pad_pd    (pad_pd)
   );

   // ---------------- assertions ----------------
   // R8: unmapped reads return zero
   p_unmapped_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !addr_mapped) |=> (reg_rdata == 8'h00));

   // R8: writes that hit no writable register leave every output alone
   p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !addr_storing) |=> ($stable(pad_oe) && $stable(pad_out)
         && $stable(pad_pu) && $stable(pad_pd) && $stable(pin_func_sel)
         && $stable(vsel_code) && $stable(alt_func)));

   for (genvar b = 0; b < BANKS; b++) begin : g_dir_chk
      if (8*b + 8 <= NUM_PINS) begin : g_full
         // R3: a direction write drives the enables of its eight pins
         p_dir_write_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(KIND_STRIDE * K_DIR + b))
            |=> (pad_oe[8*b +: 8] == $past(reg_wdata)));
      end
   end

endmodule

// File: tb/test_gpio_bank_regs.sv
`timescale 1ns/1ps
module test_gpio_bank_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [55:0] pad_in = '0;
   logic [55:0] pad_out, pad_oe, pad_pu, pad_pd, pin_func_sel;
   logic [7:0]  vsel_code, alt_func;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_bank_regs i_gpio_bank_regs (
      .clk (clk), .rst_n (rst_n),
      .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe),
      .pad_pu (pad_pu), .pad_pd (pad_pd), .pin_func_sel (pin_func_sel),
      .vsel_code (vsel_code), .alt_func (alt_func)
   );

   // {offset, write data, expected read-back}
   localparam logic [23:0] VEC [12] = '{
      24'h00_A5_A5,   // R2 function select, first byte
      24'h06_3C_3C,   // R2 function select, last byte
      24'h13_81_81,   // R2 direction
      24'h26_FF_FF,   // R2 output level
      24'h30_5A_5A,   // R2 pull-down
      24'h36_0F_0F,   // R2 pull-down, last byte
      24'h47_C3_C3,   // R9 voltage select
      24'h50_7E_7E,   // R9 alternate function
      24'h07_FF_00,   // R8 gap after a kind
      24'h4F_AA_00,   // R8 gap after the pull byte
      24'h60_11_00,   // R8 above the map
      24'h41_FF_00    // R8 input kind is not writable
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0]  r;
      logic [55:0] snap_oe, snap_pu, snap_pd;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 pad_oe", pad_oe, 0);
      check("R1 pulls", {pad_pu, pad_pd}, 0);
      check("R1 pad_out/func", {pad_out, pin_func_sel}, 0);
      do_rd(8'h48, r); check("R1 pull byte", r, 0);
      do_rd(8'h10, r); check("R1 direction byte", r, 0);

      // R2 R8 R9: table walk
      for (int v = 0; v < 12; v++) begin
         do_wr(VEC[v][23:16], VEC[v][15:8]);
         do_rd(VEC[v][23:16], r);
         check($sformatf("R2/R8/R9 table offset %0h", VEC[v][23:16]), r, VEC[v][7:0]);
      end

      // R10: function-select bits reach the pins
      check("R10 func low byte", pin_func_sel[7:0], 8'hA5);
      check("R10 func high byte", pin_func_sel[55:48], 8'h3C);
      // R9: single bytes on their outputs
      check("R9 vsel_code", vsel_code, 8'hC3);
      check("R9 alt_func", alt_func, 8'h7E);

      // R3: direction 0x13 = 81 drives pins 25 and 32
      check("R3 oe from direction", pad_oe, 56'h81 << 24);
      check("R3 out independent of direction", pad_out[55:48], 8'hFF);
      do_wr(8'h10, 8'h01);
      do_wr(8'h20, 8'h01);
      check("R3 pin1 enable", pad_oe[0], 1'b1);
      check("R3 pin1 level", pad_out[0], 1'b1);

      // R4: legacy pull-down for pins outside 51..54; R5: legacy ignored inside
      check("R4 pull-down low byte", pad_pd[7:0], 8'h5A);
      check("R4 no pull-up low byte", pad_pu[7:0], 8'h00);
      check("R5 legacy bits ignored for 51/52", pad_pd[55:48], 8'h03);

      // R5: field 0x39 -> pin51=01 down, pin52=10 up, pin53=11 none, pin54=00 none
      do_wr(8'h48, 8'h39);
      check("R5 field pull-down", pad_pd[55:48], 8'h07);
      check("R5 field pull-up", pad_pu[55:48], 8'h08);

      // R6: pins 49 and 52 become outputs, their pulls drop
      do_wr(8'h16, 8'h09);
      check("R6 enables", pad_oe[55:48], 8'h09);
      check("R6 pull-down forced off", pad_pd[55:48], 8'h06);
      check("R6 pull-up forced off", pad_pu[55:48], 8'h00);

      // R7: synchronizer latency, read held across the change
      @(negedge clk);
      pad_in = 56'h80_0000_0000_0101;   // pins 1, 9, 56
      reg_rd = 1'b1; reg_addr = 8'h40;
      @(negedge clk); check("R7 first edge old", reg_rdata, 8'h00);
      @(negedge clk); check("R7 second edge old", reg_rdata, 8'h00);
      @(negedge clk); check("R7 third edge new", reg_rdata, 8'h01);
      reg_rd = 1'b0;
      do_rd(8'h41, r); check("R7 pin9 mapping", r, 8'h01);
      do_rd(8'h46, r); check("R7 pin56 mapping", r, 8'h80);

      // R8: writes to unmapped offsets and to the input kind
      snap_oe = pad_oe; snap_pu = pad_pu; snap_pd = pad_pd;
      do_wr(8'h17, 8'hFF);
      do_wr(8'h5F, 8'hFF);
      do_wr(8'h40, 8'hFE);
      check("R8 enables unchanged", pad_oe, snap_oe);
      check("R8 pulls unchanged", {pad_pu, pad_pd}, {snap_pu, snap_pd});
      do_rd(8'h40, r); check("R8 input kind still reflects pads", r, 8'h01);
      do_rd(8'h17, r); check("R8 unmapped read", r, 8'h00);

      // R1: reset in mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears enables", pad_oe, 0);
      check("R1 reset clears pulls", {pad_pu, pad_pd}, 0);
      check("R1 reset clears outputs", {vsel_code, alt_func}, 0);
      rst_n = 1'b1;
      do_rd(8'h50, r); check("R1 alt byte after reset", r, 8'h00);
      do_rd(8'h48, r); check("R1 pull byte after reset", r, 8'h00);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule